// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a processor's store port and a memory write port. It collects stores that fall inside one 32-byte aligned line into a single line-wide holding register. Repeated stores to the same bytes are folded together, and the newest value replaces the older one. A per-byte valid mask records which bytes have been written. Memory is written only when a trigger occurs: the line fills completely, a store targets a different line, or an external flush is raised. On that trigger the whole line goes out as one burst that carries the line base address, the line data and the byte mask as byte enables.

It is intended for write-through style traffic. Many narrow stores to one neighbourhood become a single wide memory write, which saves bus and memory bandwidth.

Both data interfaces use valid/ready. On the store side a store is taken on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is low for three reasons: while a burst is outstanding, while `flush` is high, and while the buffer holds data and the presented address lies outside the held line. In the last case the buffer drains on its own, and the store is then taken into a fresh line. The producer must hold its store stable until it is taken. On the memory side `mem_valid` stays high, and the address, data and enables stay unchanged, until `mem_ready` is sampled high.

Top module: `wc_store_buf`

## Requirements
- R1: After reset no burst is offered (`mem_valid` low) and, with `flush` low and the buffer empty, `st_ready` is high.
- R2: Stores whose line address (address bits above bit 4) matches the held line are taken without any memory transaction. They appear together in one later burst.
- R3: When a store writes a byte that is already valid, the byte takes the newer value.
- R4: Stores are word-aligned: address bits 1:0 are zero. Strobe bit k writes byte k of the word, with little-endian lanes. Word index = address bits 4:2. A burst carries the line base (low 5 bits zero) and `mem_be`, where bit n marks line byte n as written. Line byte n sits in `mem_data[8n+7:8n]`.
- R5: When all 32 byte-valid bits become set, a burst starts on its own in the cycle after the filling store is taken.
- R6: While the buffer is non-empty, a store to a different line is held off (`st_ready` low). The old line is drained, and the store is then taken as the first store of the new line.
- R7: A flush with a non-empty buffer starts a burst. A flush with an empty buffer produces no burst. No burst is ever offered with an empty mask.
- R8: While a burst is outstanding, `st_ready` is low. Address, data and enables stay stable until `mem_ready` is high.
- R9: After a burst is accepted, the mask clears. The next burst carries only bytes written after that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Byte address of the store (word aligned) |
| st_data | input | 8*WORD_BYTES | Store data, little-endian lanes |
| st_strb | input | WORD_BYTES | Byte strobes of the store |
| flush | input | 1 | Request to drain a non-empty buffer |
| mem_valid | output | 1 | Burst offered |
| mem_ready | input | 1 | Memory accepts the burst |
| mem_addr | output | ADDR_W | Line base address of the burst |
| mem_data | output | 8*LINE_BYTES | Line data |
| mem_be | output | LINE_BYTES | Byte enables of the burst |

## Verification
The bench rewrites a byte inside a partly filled line. A design that kept the older value, or that OR-merged the two values, would put the wrong byte in the burst. It fills a line word by word and checks that nothing leaves before the last word and that a burst leaves without a flush right after it; an off-by-one full detector would either drain early or wait for a flush. It presents a store to a second line and expects the first line's burst to carry only that line's bytes before the new store is taken. A design that merged across lines, or dropped the waiting store, shows up there. It also stalls the memory side to catch a design that takes stores or changes the payload mid-burst, and it flushes an empty buffer to catch a spurious zero-enable burst.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic {
    WCB_FILL  = 1'b0,
    WCB_DRAIN = 1'b1
  } wcb_state_t;
endpackage

// File: rtl/wcb_merge.sv
module wcb_merge #(
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int WORDS     = LINE_BYTES / WORD_BYTES,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [8*WORD_BYTES-1:0] wr_data,
  input  logic [WORD_BYTES-1:0]   wr_strb,
  input  logic [8*LINE_BYTES-1:0] cur_data,
  input  logic [LINE_BYTES-1:0]   cur_mask,
  output logic [8*LINE_BYTES-1:0] nxt_data,
  output logic [LINE_BYTES-1:0]   nxt_mask
);
  // Each line byte decides on its own whether the incoming word covers it.
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    localparam int W = b / WORD_BYTES;
    localparam int L = b % WORD_BYTES;
    logic hit;
    assign hit = (word_idx == IDX_W'(W)) && wr_strb[L];
    assign nxt_data[8*b +: 8] = hit ? wr_data[8*L +: 8] : cur_data[8*b +: 8];
    assign nxt_mask[b]        = cur_mask[b] | hit;
  end
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
  import wcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic st_valid,
  input  logic flush,
  input  logic conflict,
  input  logic nonempty,
  input  logic full_next,
  input  logic mem_ready,
  output logic st_ready,
  output logic accept,
  output logic draining,
  output logic clear
);
  wcb_state_t state_q, state_d;

  assign draining = (state_q == WCB_DRAIN);
  assign st_ready = !draining && !flush && !conflict;
  assign accept   = st_valid && st_ready;
  assign clear    = draining && mem_ready;

  always_comb begin
    state_d = state_q;
    if (draining) begin
      if (mem_ready) state_d = WCB_FILL;
    end else if ((flush && nonempty) || (st_valid && conflict) ||
                 (accept && full_next)) begin
      state_d = WCB_DRAIN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WCB_FILL;
    else        state_q <= state_d;
  end

  // R8: no store is taken while a burst is outstanding
  assert_ready_low_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !st_ready);
  // R9: an accepted burst ends the drain
  assert_drain_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && mem_ready) |=> !draining);
  // R6: a waiting store to another line triggers a drain
  assert_conflict_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!draining && st_valid && conflict) |=> draining);
endmodule

// File: rtl/wc_store_buf.sv
module wc_store_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WB_W      = $clog2(WORD_BYTES),
  localparam int IDX_W     = OFF_W - WB_W,
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [8*WORD_BYTES-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_strb,
  input  logic                    flush,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*LINE_BYTES-1:0] mem_data,
  output logic [LINE_BYTES-1:0]   mem_be
);
  logic [TAG_W-1:0]        tag_q;
  logic [8*LINE_BYTES-1:0] data_q, data_nxt;
  logic [LINE_BYTES-1:0]   mask_q, mask_nxt;
  logic [TAG_W-1:0]        st_tag;
  logic [IDX_W-1:0]        st_idx;
  logic nonempty, conflict, accept, draining, clear;

  assign st_tag   = st_addr[ADDR_W-1:OFF_W];
  assign st_idx   = st_addr[OFF_W-1:WB_W];
  assign nonempty = |mask_q;
  assign conflict = nonempty && (st_tag != tag_q);

  wcb_merge #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_merge (
    .word_idx (st_idx),
    .wr_data  (st_data),
    .wr_strb  (st_strb),
    .cur_data (data_q),
    .cur_mask (mask_q),
    .nxt_data (data_nxt),
    .nxt_mask (mask_nxt)
  );

  wcb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .flush     (flush),
    .conflict  (conflict),
    .nonempty  (nonempty),
    .full_next (&mask_nxt),
    .mem_ready (mem_ready),
    .st_ready  (st_ready),
    .accept    (accept),
    .draining  (draining),
    .clear     (clear)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (clear) begin
      mask_q <= '0;
    end else if (accept) begin
      mask_q <= mask_nxt;
      data_q <= data_nxt;
      if (!nonempty) tag_q <= st_tag;
    end
  end

  assign mem_valid = draining;
  assign mem_addr  = {tag_q, {OFF_W{1'b0}}};
  assign mem_data  = data_q;
  assign mem_be    = mask_q;

  // R4: stores arrive word aligned
  assert_store_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_addr[WB_W-1:0] == '0));
  // R7: a burst never carries an empty mask
  assert_no_empty_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != '0));
  // R5: a full line is always being drained
  assert_full_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> mem_valid);
  // R8: payload holds while memory stalls
  assert_burst_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_be) && $stable(mem_data)));
  // R9: mask is empty after an accepted burst
  assert_mask_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (mem_be == '0));
endmodule

// File: tb/wc_store_buf_bench.sv
`timescale 1ns/1ps
module wc_store_buf_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic [3:0]   st_strb = '0;
  logic         flush = 1'b0;
  logic         mem_valid;
  logic         mem_ready = 1'b1;
  logic [31:0]  mem_addr;
  logic [255:0] mem_data;
  logic [31:0]  mem_be;

  int checks = 0;
  int errors = 0;
  int bursts = 0;
  logic [31:0]  b_addr;
  logic [255:0] b_data;
  logic [31:0]  b_be;

  logic [7:0]   exp_b [32];
  logic [31:0]  exp_m;
  logic [31:0]  exp_base;

  always #4 clk = ~clk;

  wc_store_buf u_wc_store_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_strb(st_strb), .flush(flush),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be)
  );

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      bursts <= bursts + 1;
      b_addr <= mem_addr;
      b_data <= mem_data;
      b_be   <= mem_be;
    end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear(input logic [31:0] base);
    exp_m = '0;
    exp_base = base;
    for (int i = 0; i < 32; i++) exp_b[i] = 8'h00;
  endtask

  task automatic model_store(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] s);
    for (int k = 0; k < 4; k++) begin
      if (s[k]) begin
        exp_b[a[4:2]*4 + k] = d[8*k +: 8];
        exp_m[a[4:2]*4 + k] = 1'b1;
      end
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_strb = s;
    #1;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_last_burst(input string req);
    logic [255:0] exp_d, lanes;
    for (int i = 0; i < 32; i++) begin
      exp_d[8*i +: 8] = exp_m[i] ? exp_b[i] : 8'h00;
      lanes[8*i +: 8] = exp_m[i] ? 8'hFF : 8'h00;
    end
    check(b_addr == exp_base, {req, " burst address"}, 256'(b_addr), 256'(exp_base));
    check(b_be == exp_m, {req, " byte enables"}, 256'(b_be), 256'(exp_m));
    check((b_data & lanes) == exp_d, {req, " burst data"}, b_data & lanes, exp_d);
  endtask

  task automatic t_reset();
    check(mem_valid == 1'b0, "R1 mem_valid after reset", 256'(mem_valid), 256'(0));
    check(st_ready == 1'b1, "R1 st_ready after reset", 256'(st_ready), 256'(1));
    check(bursts == 0, "R1 no burst after reset", 256'(bursts), 256'(0));
  endtask

  task automatic t_merge();
    int n0 = bursts;
    model_clear(32'h100);
    store(32'h100, 32'h11223344, 4'hF); model_store(32'h100, 32'h11223344, 4'hF);
    store(32'h100, 32'h000000AA, 4'h1); model_store(32'h100, 32'h000000AA, 4'h1);
    store(32'h10C, 32'hCAFE0000, 4'hC); model_store(32'h10C, 32'hCAFE0000, 4'hC);
    settle();
    check(bursts == n0, "R2 stores held without burst", 256'(bursts), 256'(n0));
    pulse_flush(); settle();
    check(bursts == n0 + 1, "R7 flush drains once", 256'(bursts), 256'(n0 + 1));
    check_last_burst("R4");
    check(b_data[7:0] == 8'hAA, "R3 newest byte wins", 256'(b_data[7:0]), 256'(8'hAA));
    check(b_be == 32'h0000C00F, "R4 partial enables", 256'(b_be), 256'(32'h0000C00F));
  endtask

  task automatic t_flush_empty();
    int n0 = bursts;
    pulse_flush(); settle();
    check(bursts == n0, "R7 empty flush issues nothing", 256'(bursts), 256'(n0));
    check(mem_valid == 1'b0, "R9 idle after drain", 256'(mem_valid), 256'(0));
  endtask

  task automatic t_full();
    int n0 = bursts;
    model_clear(32'h200);
    for (int i = 0; i < 7; i++) begin
      store(32'h200 + 4*i, 32'hA0B0C000 + i, 4'hF);
      model_store(32'h200 + 4*i, 32'hA0B0C000 + i, 4'hF);
    end
    settle();
    check(bursts == n0, "R2 seven words still held", 256'(bursts), 256'(n0));
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h21C; st_data = 32'h5A5A5A5A; st_strb = 4'hF;
    model_store(32'h21C, 32'h5A5A5A5A, 4'hF);
    @(negedge clk);
    st_valid = 1'b0;
    check(mem_valid == 1'b1, "R5 burst starts after filling store", 256'(mem_valid), 256'(1));
    settle();
    check(bursts == n0 + 1, "R5 full line drained without flush", 256'(bursts), 256'(n0 + 1));
    check_last_burst("R5");
  endtask

  task automatic t_conflict();
    int n0 = bursts;
    model_clear(32'h300);
    store(32'h304, 32'h0000BE00, 4'h2); model_store(32'h304, 32'h0000BE00, 4'h2);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h340; st_data = 32'h00000077; st_strb = 4'h1;
    #1;
    check(st_ready == 1'b0, "R6 other-line store held off", 256'(st_ready), 256'(0));
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    settle();
    check(bursts == n0 + 1, "R6 old line drained first", 256'(bursts), 256'(n0 + 1));
    check_last_burst("R6");
    model_clear(32'h340);
    model_store(32'h340, 32'h00000077, 4'h1);
    pulse_flush(); settle();
    check(bursts == n0 + 2, "R9 new line burst", 256'(bursts), 256'(n0 + 2));
    check_last_burst("R9");
  endtask

  task automatic t_stall();
    int n0 = bursts;
    logic [31:0] a0, be0;
    mem_ready = 1'b0;
    model_clear(32'h400);
    store(32'h418, 32'hDEADBEEF, 4'h9); model_store(32'h418, 32'hDEADBEEF, 4'h9);
    pulse_flush();
    check(mem_valid == 1'b1, "R8 burst offered", 256'(mem_valid), 256'(1));
    a0 = mem_addr; be0 = mem_be;
    repeat (3) @(negedge clk);
    check(mem_valid == 1'b1, "R8 burst held under stall", 256'(mem_valid), 256'(1));
    check(st_ready == 1'b0, "R8 stores blocked in drain", 256'(st_ready), 256'(0));
    check(mem_addr == a0 && mem_be == be0, "R8 payload stable",
          {mem_addr, mem_be}, {a0, be0});
    mem_ready = 1'b1;
    settle();
    check(bursts == n0 + 1, "R8 burst accepted after stall", 256'(bursts), 256'(n0 + 1));
    check_last_burst("R8");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_merge();
    t_flush_empty();
    t_full();
    t_conflict();
    t_stall();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule